// File: doc/BRIEF.md
# Interrupt Request Priority Resolver

This block keeps the pending, in-service and trigger-kind state of every interrupt vector for one processor's local interrupt controller, and decides which vector, if any, the processor is offered. Sources post a vector with a single-cycle set strobe. The processor takes the best vector with an acknowledge strobe and retires it with an end-of-interrupt strobe. A 4-bit task priority and the highest vector still in service together set a priority floor. A request whose class, the upper four bits of the vector, does not rise above that floor is held back.

An acknowledge answers in one of three ways. It can return the vector it took. If requests exist but all are held back, it returns the spurious vector. If nothing is posted, or the block is switched off, it returns nothing. Retiring a vector that was posted as level-triggered can announce that vector to the upstream routers on a broadcast strobe. A control input can turn this announcement off.

Top module: `irq_prio_resolver`

## Requirements
- R1: The best vector of a 256-bit set is its highest-numbered set bit. The search runs across 32-bit words. When no bit is set there is no best vector.
- R2: A set strobe marks the vector as requested. It records the vector's trigger kind: level when `set_level` is 1, edge when it is 0.
- R3: One cycle after a set strobe, `set_fresh` is 1 if the vector's request bit was clear before the strobe, and 0 if it was already set. It is 0 in every cycle that does not follow a set strobe.
- R4: A task-priority write stores `tpr_nib` in the upper four bits of an 8-bit priority, with the lower four bits zero. A request is held back when the effective priority is nonzero and the request's class is less than or equal to the effective priority's class.
- R5: The effective priority is the task priority when that is at least the in-service class (the highest in-service vector with its lower four bits cleared). Otherwise it is the in-service class. With nothing in service it is the task priority.
- R6: `irq_req` is 1 exactly when the block is enabled and a request that is not held back exists. An acknowledge of such a request clears its request bit and sets its in-service bit. One cycle later `ack_kind` = 1 and `ack_vec` gives the vector.
- R7: If every request is held back, an acknowledge changes no state and gives `ack_kind` = 2 with `ack_vec` = `spur_vec`. With no request at all it gives `ack_kind` = 0. Outside the cycle after an acknowledge, `ack_kind` is 0.
- R8: An end-of-interrupt strobe clears the highest in-service bit. If that vector was recorded as level-triggered and `directed_eoi` is 0, then one cycle later `eoi_bc_stb` is 1 and `eoi_bc_vec` gives the vector. With nothing in service the strobe does nothing.
- R9: While `directed_eoi` is 1, retiring a level-triggered vector raises no broadcast. Retiring an edge-triggered vector never raises one.
- R10: While `sw_enable` is 0, `irq_req` stays 0 and an acknowledge gives `ack_kind` = 0 without changing any request or in-service bit.
- R11: When a set and an acknowledge fall in the same cycle, the acknowledge decision uses the state before the cycle. The set is applied after the acknowledge's clear, so a set of the acknowledged vector leaves its request bit set.
- R12: After reset all vector sets and the task priority are zero, `irq_req` is 0 and all strobe outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_stb | input | 1 | Post a vector request (one-cycle pulse) |
| set_vec | input | 8 | Vector being posted |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_stb | input | 1 | Processor acknowledge (one-cycle pulse) |
| eoi_stb | input | 1 | End of interrupt (one-cycle pulse) |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_nib | input | 4 | Task priority class to store |
| sw_enable | input | 1 | Software enable of the controller |
| directed_eoi | input | 1 | 1 suppresses the end-of-interrupt broadcast |
| spur_vec | input | 8 | Vector returned for a held-back acknowledge |
| irq_req | output | 1 | Interrupt request to the processor |
| ack_kind | output | 2 | Acknowledge answer: 0 none, 1 vector, 2 spurious |
| ack_vec | output | 8 | Vector answered by the acknowledge |
| eoi_bc_stb | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bc_vec | output | 8 | Vector carried by the broadcast |
| set_fresh | output | 1 | Previous set found its request bit clear |

## Verification
The bench targets class ties. A request in the same class as the vector in service must be held back and must draw the spurious answer. A design that compared with less-than instead of less-or-equal would nest a vector under one of its own class. Another case lets the in-service class outrank a lower task priority and then lets a higher task priority outrank it; a design that used only one source of priority would release or block the wrong request. The bench also posts a vector in the same cycle it is acknowledged, which catches a design that applies the acknowledge clear after the set. It retires edge, level and directed cases, which catches a broadcast keyed to the wrong vector or to the trigger bit of the next vector in line. Requests on both sides of a 32-bit word boundary check the word search.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_VEC  = 2'd1,
        ACK_SPUR = 2'd2
    } ack_kind_e;

endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
    parameter int NUM    = 256,
    parameter int WORD_W = 32,
    parameter int IDX_W  = $clog2(NUM)
) (
    input  logic [NUM-1:0]   bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    localparam int NWORDS = NUM / WORD_W;
    localparam int BIT_W  = $clog2(WORD_W);

    logic [NWORDS-1:0]            word_any;
    logic [NWORDS-1:0][BIT_W-1:0] word_top;

    // per-word highest set bit
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [BIT_W-1:0] top_d;
        always_comb begin
            top_d = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) top_d = BIT_W'(b);
            end
        end
        assign word_any[w] = |bits[w*WORD_W +: WORD_W];
        assign word_top[w] = top_d;
    end

    // highest non-empty word wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_any[w]) begin
                found = 1'b1;
                idx   = IDX_W'(w * WORD_W) + IDX_W'(word_top[w]);
            end
        end
    end

    // R1: the reported index points at a set bit, and "none" means empty
    always_comb begin
        if (found === 1'b1) begin
            a_r1_hit_is_set: assert (bits[idx] !== 1'b0);
        end
        if (found === 1'b0) begin
            a_r1_none_is_empty: assert ((|bits) !== 1'b1);
        end
    end

endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_top,
    output logic             deliverable,
    output logic             blocked
);
    localparam int SUB_W = VEC_W - CLS_W;

    logic [VEC_W-1:0] isr_cls;
    logic [VEC_W-1:0] ppr;
    logic             hold;

    assign isr_cls = isr_found ? {isr_top[VEC_W-1 -: CLS_W], {SUB_W{1'b0}}} : '0;
    assign ppr     = (tpr >= isr_cls) ? tpr : isr_cls;
    assign hold    = (ppr != '0) &&
                     (irr_top[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);

    assign deliverable = irr_found && !hold;
    assign blocked     = irr_found && hold;

    // R5: effective priority never falls below either of its sources
    always_comb begin
        a_r5_ppr_floor: assert (!(ppr < tpr) && !(ppr < isr_cls));
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int CLS_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_stb,
    input  logic [$clog2(NUM_VEC)-1:0] set_vec,
    input  logic                       set_level,
    input  logic                       ack_stb,
    input  logic                       eoi_stb,
    input  logic                       tpr_wr,
    input  logic [CLS_W-1:0]           tpr_nib,
    input  logic                       sw_enable,
    input  logic                       directed_eoi,
    input  logic [$clog2(NUM_VEC)-1:0] spur_vec,
    output logic                       irq_req,
    output logic [1:0]                 ack_kind,
    output logic [$clog2(NUM_VEC)-1:0] ack_vec,
    output logic                       eoi_bc_stb,
    output logic [$clog2(NUM_VEC)-1:0] eoi_bc_vec,
    output logic                       set_fresh
);
    localparam int VEC_W = $clog2(NUM_VEC);
    localparam int SUB_W = VEC_W - CLS_W;

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VEC_W-1:0]   tpr;
        ack_kind_e          ack_kind;
        logic [VEC_W-1:0]   ack_vec;
        logic               bc_stb;
        logic [VEC_W-1:0]   bc_vec;
        logic               fresh;
    } state_t;

    state_t st_d, st_q;

    logic             irr_found, isr_found;
    logic [VEC_W-1:0] irr_top, isr_top;
    logic             deliverable, blocked;

    irq_prio_find #(.NUM(NUM_VEC), .WORD_W(WORD_W), .IDX_W(VEC_W)) i_find_irr (
        .bits  (st_q.irr),
        .found (irr_found),
        .idx   (irr_top)
    );

    irq_prio_find #(.NUM(NUM_VEC), .WORD_W(WORD_W), .IDX_W(VEC_W)) i_find_isr (
        .bits  (st_q.isr),
        .found (isr_found),
        .idx   (isr_top)
    );

    irq_prio_gate #(.VEC_W(VEC_W), .CLS_W(CLS_W)) i_gate (
        .tpr         (st_q.tpr),
        .isr_found   (isr_found),
        .isr_top     (isr_top),
        .irr_found   (irr_found),
        .irr_top     (irr_top),
        .deliverable (deliverable),
        .blocked     (blocked)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ack_kind = ACK_NONE;
        st_d.ack_vec  = '0;
        st_d.bc_stb   = 1'b0;
        st_d.bc_vec   = '0;
        st_d.fresh    = 1'b0;

        if (tpr_wr) begin
            st_d.tpr = {tpr_nib, {SUB_W{1'b0}}};
        end

        // retire the highest vector in service
        if (eoi_stb && isr_found) begin
            st_d.isr[isr_top] = 1'b0;
            if (st_q.tmr[isr_top] && !directed_eoi) begin
                st_d.bc_stb = 1'b1;
                st_d.bc_vec = isr_top;
            end
        end

        // acknowledge decided on pre-cycle state
        if (ack_stb && sw_enable) begin
            if (deliverable) begin
                st_d.irr[irr_top] = 1'b0;
                st_d.isr[irr_top] = 1'b1;
                st_d.ack_kind     = ACK_VEC;
                st_d.ack_vec      = irr_top;
            end else if (blocked) begin
                st_d.ack_kind = ACK_SPUR;
                st_d.ack_vec  = spur_vec;
            end
        end

        // set lands after the acknowledge clear
        if (set_stb) begin
            st_d.fresh        = !st_q.irr[set_vec];
            st_d.irr[set_vec] = 1'b1;
            st_d.tmr[set_vec] = set_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req    = sw_enable && deliverable;
    assign ack_kind   = st_q.ack_kind;
    assign ack_vec    = st_q.ack_vec;
    assign eoi_bc_stb = st_q.bc_stb;
    assign eoi_bc_vec = st_q.bc_vec;
    assign set_fresh  = st_q.fresh;

    // R2: a posted vector is requested next cycle with its trigger kind
    a_r2_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> (st_q.irr[$past(set_vec)] &&
                     st_q.tmr[$past(set_vec)] == $past(set_level)));

    // R6: an acknowledged vector is in service when it is reported
    a_r6_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ack_kind == ACK_VEC) |-> st_q.isr[st_q.ack_vec]);

    // R7: the spurious answer carries the spurious vector
    a_r7_spur_value: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ack_kind == ACK_SPUR) |-> (st_q.ack_vec == $past(spur_vec) && $past(ack_stb)));

    // R8 / R9: a broadcast follows an undirected end of interrupt only
    a_r8_bc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_stb |-> ($past(eoi_stb) && !$past(directed_eoi)));

    // R10: no request reaches the processor while disabled
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |-> !irq_req);

    // R3: freshness flag only follows a set strobe
    a_r3_fresh_cause: assert property (@(posedge clk) disable iff (!rst_n)
        set_fresh |-> $past(set_stb));

endmodule

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_stb = 1'b0;
    logic [7:0] set_vec = '0;
    logic       set_level = 1'b0;
    logic       ack_stb = 1'b0;
    logic       eoi_stb = 1'b0;
    logic       tpr_wr = 1'b0;
    logic [3:0] tpr_nib = '0;
    logic       sw_enable = 1'b1;
    logic       directed_eoi = 1'b0;
    logic [7:0] spur_vec = 8'hAF;
    logic       irq_req;
    logic [1:0] ack_kind;
    logic [7:0] ack_vec;
    logic       eoi_bc_stb;
    logic [7:0] eoi_bc_vec;
    logic       set_fresh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_resolver i_irq_prio_resolver (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_stb      (set_stb),
        .set_vec      (set_vec),
        .set_level    (set_level),
        .ack_stb      (ack_stb),
        .eoi_stb      (eoi_stb),
        .tpr_wr       (tpr_wr),
        .tpr_nib      (tpr_nib),
        .sw_enable    (sw_enable),
        .directed_eoi (directed_eoi),
        .spur_vec     (spur_vec),
        .irq_req      (irq_req),
        .ack_kind     (ack_kind),
        .ack_vec      (ack_vec),
        .eoi_bc_stb   (eoi_bc_stb),
        .eoi_bc_vec   (eoi_bc_vec),
        .set_fresh    (set_fresh)
    );

    // op: 0 set edge, 1 set level, 2 ack, 3 eoi
    // {op, vec, expected flag/kind, expected vector}
    localparam logic [19:0] TBL [28] = '{
        {2'd0, 8'h31, 2'd1, 8'h00},
        {2'd0, 8'h31, 2'd0, 8'h00},
        {2'd1, 8'h85, 2'd1, 8'h00},
        {2'd0, 8'h40, 2'd1, 8'h00},
        {2'd2, 8'h00, 2'd1, 8'h85},
        {2'd2, 8'h00, 2'd2, 8'hAF},
        {2'd3, 8'h00, 2'd1, 8'h85},
        {2'd2, 8'h00, 2'd1, 8'h40},
        {2'd0, 8'h4A, 2'd1, 8'h00},
        {2'd2, 8'h00, 2'd2, 8'hAF},
        {2'd3, 8'h00, 2'd0, 8'h00},
        {2'd2, 8'h00, 2'd1, 8'h4A},
        {2'd2, 8'h00, 2'd2, 8'hAF},
        {2'd3, 8'h00, 2'd0, 8'h00},
        {2'd2, 8'h00, 2'd1, 8'h31},
        {2'd3, 8'h00, 2'd0, 8'h00},
        {2'd2, 8'h00, 2'd0, 8'h00},
        {2'd3, 8'h00, 2'd0, 8'h00},
        {2'd0, 8'h05, 2'd1, 8'h00},
        {2'd1, 8'hE0, 2'd1, 8'h00},
        {2'd2, 8'h00, 2'd1, 8'hE0},
        {2'd2, 8'h00, 2'd2, 8'hAF},
        {2'd3, 8'h00, 2'd1, 8'hE0},
        {2'd2, 8'h00, 2'd1, 8'h05},
        {2'd3, 8'h00, 2'd0, 8'h00},
        {2'd0, 8'hFF, 2'd1, 8'h00},
        {2'd2, 8'h00, 2'd1, 8'hFF},
        {2'd3, 8'h00, 2'd0, 8'h00}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive strobes at a falling edge, return at the next falling edge
    task automatic step(input bit s, input logic [7:0] v, input bit lvl,
                        input bit a, input bit e);
        set_stb   = s;
        set_vec   = v;
        set_level = lvl;
        ack_stb   = a;
        eoi_stb   = e;
        @(negedge clk);
        set_stb = 1'b0;
        ack_stb = 1'b0;
        eoi_stb = 1'b0;
    endtask

    task automatic write_tpr(input logic [3:0] nib);
        tpr_wr  = 1'b1;
        tpr_nib = nib;
        @(negedge clk);
        tpr_wr = 1'b0;
    endtask

    task automatic ack_expect(input string tag, input int kind, input int vec);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        chk(tag, ack_kind, kind);
        if (kind != 0) chk(tag, ack_vec, vec);
    endtask

    task automatic eoi_expect(input string tag, input int bc, input int vec);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk(tag, eoi_bc_stb, bc);
        if (bc != 0) chk(tag, eoi_bc_vec, vec);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 irq_req", irq_req, 0);
        chk("R12 ack_kind", ack_kind, 0);
        chk("R12 eoi_bc_stb", eoi_bc_stb, 0);
        chk("R12 set_fresh", set_fresh, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after release", irq_req, 0);

        for (int i = 0; i < 28; i++) begin
            logic [1:0] op;
            logic [7:0] v, ev;
            logic [1:0] ea;
            {op, v, ea, ev} = TBL[i];
            case (op)
                2'd0, 2'd1: begin
                    step(1'b1, v, op[0], 1'b0, 1'b0);
                    chk($sformatf("R3 row %0d fresh", i), set_fresh, ea);
                end
                2'd2: ack_expect($sformatf("R6 R7 R1 row %0d ack", i), ea, ev);
                default: eoi_expect($sformatf("R8 R2 row %0d eoi", i), ea, ev);
            endcase
        end

        // R4: task priority class 5 blocks 0x5F, passes 0x60
        write_tpr(4'h5);
        step(1'b1, 8'h5F, 1'b0, 1'b0, 1'b0);
        chk("R4 class tie blocked", irq_req, 0);
        step(1'b1, 8'h60, 1'b0, 1'b0, 1'b0);
        chk("R4 higher class passes", irq_req, 1);
        ack_expect("R4 ack above tpr", 1, 8'h60);

        // R5: in-service class 6 outranks tpr 0x50
        step(1'b1, 8'h6C, 1'b0, 1'b0, 1'b0);
        chk("R5 in-service class blocks", irq_req, 0);
        ack_expect("R5 spurious under isr", 2, 8'hAF);
        write_tpr(4'h0);
        chk("R5 isr still blocks", irq_req, 0);
        eoi_expect("R5 R9 edge retire", 0, 0);
        chk("R5 released after eoi", irq_req, 1);
        write_tpr(4'h7);
        chk("R5 tpr above isr blocks", irq_req, 0);
        write_tpr(4'h0);
        ack_expect("R5 ack 6C", 1, 8'h6C);
        eoi_expect("R5 retire 6C", 0, 0);
        ack_expect("R5 ack 5F", 1, 8'h5F);
        eoi_expect("R5 retire 5F", 0, 0);

        // R9: directed end of interrupt suppresses broadcast
        step(1'b1, 8'h90, 1'b1, 1'b0, 1'b0);
        directed_eoi = 1'b1;
        ack_expect("R9 ack 90", 1, 8'h90);
        eoi_expect("R9 directed no broadcast", 0, 0);
        directed_eoi = 1'b0;

        // R10: disabled controller
        step(1'b1, 8'h70, 1'b0, 1'b0, 1'b0);
        sw_enable = 1'b0;
        #1;
        chk("R10 irq_req off", irq_req, 0);
        ack_expect("R10 ack none", 0, 0);
        sw_enable = 1'b1;
        #1;
        chk("R10 request kept", irq_req, 1);
        ack_expect("R10 ack after enable", 1, 8'h70);
        eoi_expect("R10 retire 70", 0, 0);

        // R11: set and acknowledge of the same vector in one cycle
        step(1'b1, 8'h20, 1'b0, 1'b0, 1'b0);
        chk("R11 first post fresh", set_fresh, 1);
        step(1'b1, 8'h20, 1'b0, 1'b1, 1'b0);
        chk("R11 ack kind", ack_kind, 1);
        chk("R11 ack vec", ack_vec, 8'h20);
        chk("R11 repost not fresh", set_fresh, 0);
        chk("R11 repost held by isr", irq_req, 0);
        ack_expect("R11 request survived", 2, 8'hAF);
        eoi_expect("R11 retire", 0, 0);
        ack_expect("R11 ack again", 1, 8'h20);
        eoi_expect("R11 retire again", 0, 0);

        // R1: word boundary between 0x1F and 0x20
        step(1'b1, 8'h1F, 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'h20, 1'b0, 1'b0, 1'b0);
        ack_expect("R1 upper word wins", 1, 8'h20);
        eoi_expect("R1 retire 20", 0, 0);
        ack_expect("R1 lower word next", 1, 8'h1F);
        eoi_expect("R1 retire 1F", 0, 0);
        chk("R7 all idle", ack_kind, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule